// File: doc/BRIEF.md
# Single-Edge Nibble Frame Transmitter

This block drives one output pin with single-edge nibble frames. A frame is a calibration (sync) pulse, a status nibble, between one and six data nibbles, a check nibble and, when asked for, a closing pause pulse. Every pulse opens with a short period at the active (low) level and then sits at the inactive level until the pulse has lasted its full length. The value of a nibble is carried only by how long its pulse lasts, counted in ticks. A tick is either one clock cycle or four clock cycles.

Frames can be sent in two ways. In free-running mode they follow each other with no gap for as long as the block is enabled. In triggered mode one frame goes out for each strobe. The pin polarity can be inverted as a whole, and the check nibble can be a 4-bit CRC or a fixed zero. The status nibble, the data nibbles and all of the configuration are captured at the first edge of each frame. Changing them while a frame is in flight therefore affects only the next frame.

Top module: `sent_tx`

## Requirements
- R1: The block sends only while `enable`=1, `rxMode`=0 and `nibCount` is 1 to 6. Codes 0 and 7 are reserved and inhibit sending. If any of these conditions fails during a frame, that frame stops at once: `busy` is 0 from the next cycle, the pin returns to its idle level, and `frameDone` does not pulse.
- R2: With `invPol`=0 the pin idles high. With `invPol`=1 it idles low and the whole frame waveform is inverted. The polarity used for a frame is the one captured at its start.
- R3: Each pulse spends its first 5 ticks at the active level (low when `invPol`=0) and its remaining ticks at the inactive level. The sync pulse lasts 56 ticks. A nibble of value v lasts 12+v ticks.
- R4: Pulses are sent in this order: sync, status, data nibbles 0 to n-1, check nibble, then the pause pulse if `pauseOn`=1. Data nibble i is taken from `dataNibs[4i+3:4i]`, and n is `nibCount`.
- R5: When `crcOn`=1 the check nibble is the CRC with polynomial x^4+x^3+x^2+1 and seed 0101. The CRC runs over the data nibbles in send order, followed by one appended zero nibble; the status nibble is not included. When `crcOn`=0 the check nibble is 0.
- R6: The pause pulse lasts `pauseLen` ticks, limited to the range 12 to 768: smaller values give 12 and larger values give 768.
- R7: With `slowTick`=0 a tick is one clock cycle. With `slowTick`=1 a tick is four clock cycles.
- R8: In free-running mode (`trigMode`=0) frames follow each other with no idle cycle between them. `frameDone` is high for exactly one cycle, the cycle after the last cycle of each completed frame.
- R9: In triggered mode (`trigMode`=1) with no frame in progress, a `trigger` sampled high starts exactly one frame. `busy` is high and the first active-level tick appears in the very next cycle, and the block returns to idle after that frame.
- R10: In triggered mode, a trigger that arrives during a frame is kept pending, and the next frame starts directly after the current one. Several such triggers within one frame give only one extra frame. In free-running mode `trigger` has no effect.
- R11: The status nibble, data nibbles, nibble count, check enable, pause enable, pause length, prescale and polarity are captured at the first edge of each frame. Changes made during a frame do not alter that frame.
- R12: `busy` is high in exactly the cycles that carry frame ticks and low at all other times, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Master enable |
| rxMode | input | 1 | Receive selection; 1 inhibits transmission |
| trigMode | input | 1 | 0 free-running, 1 one frame per trigger |
| invPol | input | 1 | 0 idle high, 1 idle low with inverted waveform |
| crcOn | input | 1 | 1 sends the CRC, 0 sends a zero check nibble |
| pauseOn | input | 1 | Appends a pause pulse to each frame |
| slowTick | input | 1 | 0 one cycle per tick, 1 four cycles per tick |
| nibCount | input | 3 | Data nibbles per frame, 1 to 6 |
| statusNib | input | 4 | Status nibble value |
| dataNibs | input | 24 | Data nibbles; nibble i in bits 4i+3:4i |
| pauseLen | input | 10 | Pause pulse length in ticks |
| trigger | input | 1 | One-cycle frame request in triggered mode |
| txOut | output | 1 | Frame output pin |
| busy | output | 1 | High while a frame is on the pin |
| frameDone | output | 1 | One-cycle pulse after each completed frame |

## Verification
The assertions check invariants that can be judged from a single cycle. They check that the block never stays busy once it is inactive and that a completion pulse never lasts two cycles. They also check that the pulse index never passes the end of the frame, that the tick count stays below the current pulse length, that every pulse length lies between 12 and 768 ticks, and that a trigger arriving mid-frame is recorded as pending. Other behaviour can only be shown by the bench scenarios, because it depends on whole frames. These scenarios cover the exact tick lengths and their order, the CRC value, pause limiting, the prescaled timing, the lack of any gap between free-running frames, the count of frames per trigger, and capture of the configuration at frame start. They do this by comparing the pin against an independent model on every clock.

// File: rtl/sent_tx_pkg.sv
package sent_tx_pkg;
  localparam int CNT_W = 3;   // width of the nibble-count field
  localparam int SEL_W = 4;   // pulse index: sync, status, up to 6 data, check, pause

  typedef struct packed {
    logic             load;      // capture inputs and restart counters
    logic             run;       // a frame occupies the pin
    logic [SEL_W-1:0] pulseSel;  // which pulse of the frame is in progress
    logic [CNT_W-1:0] dataCnt;   // captured data nibble count
  } txStrobe_t;
endpackage

// File: rtl/sent_tx_ctrl.sv
module sent_tx_ctrl
  import sent_tx_pkg::*;
#(
  parameter int NIB_MAX = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             rxMode,
  input  logic             trigMode,
  input  logic             pauseOn,
  input  logic [CNT_W-1:0] nibCount,
  input  logic             trigger,
  input  logic             pulseEnd,
  output txStrobe_t        strobe,
  output logic             busy,
  output logic             frameDone
);
  logic             active;
  logic             startReq;
  logic             frameEnd;
  logic             doLoad;
  logic             pending;
  logic             pauseLat;
  logic [CNT_W-1:0] cntLat;
  logic [SEL_W-1:0] pulseIdx;
  logic [SEL_W-1:0] lastIdx;

  always_comb begin
    active   = enable && !rxMode && (nibCount != '0) && (int'(nibCount) <= NIB_MAX);
    startReq = active && (!trigMode || trigger || pending);
    lastIdx  = SEL_W'(cntLat) + SEL_W'(2) + SEL_W'(pauseLat);
    frameEnd = busy && pulseEnd && (pulseIdx == lastIdx);
    doLoad   = startReq && (!busy || frameEnd);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      pending   <= 1'b0;
      frameDone <= 1'b0;
      pulseIdx  <= '0;
      cntLat    <= '0;
      pauseLat  <= 1'b0;
    end else begin
      frameDone <= active && frameEnd;
      if (!active) begin
        busy     <= 1'b0;
        pending  <= 1'b0;
        pulseIdx <= '0;
      end else if (doLoad) begin
        busy     <= 1'b1;
        pending  <= 1'b0;
        pulseIdx <= '0;
        cntLat   <= nibCount;
        pauseLat <= pauseOn;
      end else if (frameEnd) begin
        busy <= 1'b0;
      end else begin
        if (busy && pulseEnd) pulseIdx <= pulseIdx + SEL_W'(1);
        if (busy && trigMode && trigger) pending <= 1'b1;
      end
    end
  end

  always_comb begin
    strobe.load     = active && doLoad;
    strobe.run      = busy;
    strobe.pulseSel = pulseIdx;
    strobe.dataCnt  = cntLat;
  end

  AST_INACTIVE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> (!busy && !frameDone)); // R1
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (pulseIdx <= lastIdx)); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone); // R8
  AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (active && busy && !frameEnd && trigMode && trigger) |=> pending); // R10
endmodule

// File: rtl/sent_tx_dp.sv
module sent_tx_dp
  import sent_tx_pkg::*;
#(
  parameter int NIB_MAX    = 6,
  parameter int PAUSE_W    = 10,
  parameter int LOW_TICKS  = 5,
  parameter int BASE_TICKS = 12,
  parameter int SYNC_TICKS = 56,
  parameter int PAUSE_MIN  = 12,
  parameter int PAUSE_MAX  = 768,
  parameter int PRESCALE   = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  txStrobe_t            strobe,
  input  logic                 invPol,
  input  logic                 crcOn,
  input  logic                 slowTick,
  input  logic [CNT_W-1:0]     nibCount,
  input  logic [3:0]           statusNib,
  input  logic [NIB_MAX*4-1:0] dataNibs,
  input  logic [PAUSE_W-1:0]   pauseLen,
  output logic                 pulseEnd,
  output logic                 txOut
);
  localparam int LEN_W = $clog2(PAUSE_MAX + 1);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int IDX_W = (NIB_MAX > 1) ? $clog2(NIB_MAX) : 1;
  localparam logic [4:0] CRC_POLY = 5'h1D;
  localparam logic [3:0] CRC_SEED = 4'h5;

  logic [NIB_MAX*4-1:0] dataLat;
  logic [3:0]           statusLat;
  logic [3:0]           crcLat;
  logic [LEN_W-1:0]     pauseLat;
  logic                 slowLat;
  logic                 polLat;
  logic [LEN_W-1:0]     tickCnt;
  logic [PRE_W-1:0]     preCnt;
  logic                 tick;
  logic [LEN_W-1:0]     curLen;
  logic [SEL_W-1:0]     dSel;
  logic [3:0]           dataArr [NIB_MAX];

  for (genvar g = 0; g < NIB_MAX; g++) begin : gUnpack
    assign dataArr[g] = dataLat[4*g +: 4];
  end

  function automatic logic [3:0] crcStep(input logic [3:0] c, input logic [3:0] nib);
    logic [7:0] r;
    r = {c, 4'b0000};
    for (int b = 7; b >= 4; b--) begin
      if (r[b]) r = r ^ (8'(CRC_POLY) << (b - 4));
    end
    return r[3:0] ^ nib;
  endfunction

  function automatic logic [3:0] crcCalc(input logic [NIB_MAX*4-1:0] d,
                                         input logic [CNT_W-1:0] cnt);
    logic [3:0] c;
    c = CRC_SEED;
    for (int i = 0; i < NIB_MAX; i++) begin
      if (i < int'(cnt)) c = crcStep(c, d[4*i +: 4]);
    end
    return crcStep(c, 4'h0);
  endfunction

  function automatic logic [LEN_W-1:0] clampPause(input logic [PAUSE_W-1:0] p);
    if (int'(p) < PAUSE_MIN)      return LEN_W'(PAUSE_MIN);
    else if (int'(p) > PAUSE_MAX) return LEN_W'(PAUSE_MAX);
    else                          return LEN_W'(p);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataLat   <= '0;
      statusLat <= '0;
      crcLat    <= '0;
      pauseLat  <= LEN_W'(PAUSE_MIN);
      slowLat   <= 1'b0;
      polLat    <= 1'b0;
    end else if (strobe.load) begin
      dataLat   <= dataNibs;
      statusLat <= statusNib;
      crcLat    <= crcOn ? crcCalc(dataNibs, nibCount) : 4'h0;
      pauseLat  <= clampPause(pauseLen);
      slowLat   <= slowTick;
      polLat    <= invPol;
    end
  end

  always_comb begin
    tick = !slowLat || (preCnt == PRE_W'(PRESCALE - 1));
    dSel = strobe.pulseSel - SEL_W'(2);
    if (strobe.pulseSel == '0)
      curLen = LEN_W'(SYNC_TICKS);
    else if (strobe.pulseSel == SEL_W'(1))
      curLen = LEN_W'(BASE_TICKS) + LEN_W'(statusLat);
    else if (strobe.pulseSel <= SEL_W'(strobe.dataCnt) + SEL_W'(1))
      curLen = LEN_W'(BASE_TICKS) + LEN_W'(dataArr[IDX_W'(dSel)]);
    else if (strobe.pulseSel == SEL_W'(strobe.dataCnt) + SEL_W'(2))
      curLen = LEN_W'(BASE_TICKS) + LEN_W'(crcLat);
    else
      curLen = pauseLat;
    pulseEnd = strobe.run && tick && (tickCnt == curLen - LEN_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (strobe.load) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (strobe.run) begin
      preCnt <= (preCnt == PRE_W'(PRESCALE - 1)) ? '0 : preCnt + PRE_W'(1);
      if (tick) tickCnt <= pulseEnd ? '0 : tickCnt + LEN_W'(1);
    end
  end

  always_comb begin
    if (strobe.run) txOut = polLat ^ (tickCnt >= LEN_W'(LOW_TICKS));
    else            txOut = ~invPol;
  end

  AST_TICK_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    strobe.run |-> (tickCnt < curLen)); // R3
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.run |-> (curLen >= LEN_W'(BASE_TICKS) && curLen <= LEN_W'(PAUSE_MAX))); // R6
endmodule

// File: rtl/sent_tx.sv
module sent_tx
  import sent_tx_pkg::*;
#(
  parameter int NIB_MAX = 6,
  parameter int PAUSE_W = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enable,
  input  logic                 rxMode,
  input  logic                 trigMode,
  input  logic                 invPol,
  input  logic                 crcOn,
  input  logic                 pauseOn,
  input  logic                 slowTick,
  input  logic [2:0]           nibCount,
  input  logic [3:0]           statusNib,
  input  logic [NIB_MAX*4-1:0] dataNibs,
  input  logic [PAUSE_W-1:0]   pauseLen,
  input  logic                 trigger,
  output logic                 txOut,
  output logic                 busy,
  output logic                 frameDone
);
  txStrobe_t strobe;
  logic      pulseEnd;

  sent_tx_ctrl #(.NIB_MAX(NIB_MAX)) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .rxMode(rxMode),
    .trigMode(trigMode), .pauseOn(pauseOn), .nibCount(nibCount),
    .trigger(trigger), .pulseEnd(pulseEnd), .strobe(strobe),
    .busy(busy), .frameDone(frameDone)
  );

  sent_tx_dp #(.NIB_MAX(NIB_MAX), .PAUSE_W(PAUSE_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .invPol(invPol),
    .crcOn(crcOn), .slowTick(slowTick), .nibCount(nibCount),
    .statusNib(statusNib), .dataNibs(dataNibs), .pauseLen(pauseLen),
    .pulseEnd(pulseEnd), .txOut(txOut)
  );
endmodule

// File: tb/sim_sent_tx.sv
module sim_sent_tx;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 0, rxMode = 0, trigMode = 0, invPol = 0, crcOn = 0;
  logic pauseOn = 0, slowTick = 0, trigger = 0;
  logic [2:0]  nibCount = 3'd6;
  logic [3:0]  statusNib = 4'h0;
  logic [23:0] dataNibs = '0;
  logic [9:0]  pauseLen = 10'd12;
  logic txOut, busy, frameDone;

  always #4 clk = ~clk;

  sent_tx u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .rxMode(rxMode),
    .trigMode(trigMode), .invPol(invPol), .crcOn(crcOn), .pauseOn(pauseOn),
    .slowTick(slowTick), .nibCount(nibCount), .statusNib(statusNib),
    .dataNibs(dataNibs), .pauseLen(pauseLen), .trigger(trigger),
    .txOut(txOut), .busy(busy), .frameDone(frameDone)
  );

  int compared = 0;
  int mismatched = 0;
  int doneCnt = 0;
  int cyc = 0;
  string curReq = "R2";

  // reference model state
  bit q[$];
  bit mBusy = 0, mPend = 0, mDone = 0, mPol = 0;
  int crcTbl[16] = '{0, 13, 7, 10, 14, 3, 9, 4, 1, 12, 6, 11, 15, 2, 8, 5};

  task automatic chk(bit ok, string req, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  function automatic int refCrc(logic [23:0] d, int n);
    int c = 5;
    for (int i = 0; i < n; i++) c = crcTbl[c] ^ int'(d[4*i +: 4]);
    return crcTbl[c];
  endfunction

  task automatic pushPulse(int len, int per);
    for (int t = 0; t < len; t++)
      for (int k = 0; k < per; k++) q.push_back(t >= 5);
  endtask

  task automatic buildFrame();
    int n = int'(nibCount);
    int per = slowTick ? 4 : 1;
    int pl = int'(pauseLen);
    q.delete();
    mPol = invPol;
    pushPulse(56, per);
    pushPulse(12 + int'(statusNib), per);
    for (int i = 0; i < n; i++) pushPulse(12 + int'(dataNibs[4*i +: 4]), per);
    pushPulse(12 + (crcOn ? refCrc(dataNibs, n) : 0), per);
    if (pauseOn) begin
      if (pl < 12) pl = 12;
      if (pl > 768) pl = 768;
      pushPulse(pl, per);
    end
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mBusy = 0; mPend = 0; mDone = 0; q.delete();
    end else begin
      bit act, sreq;
      act  = enable && !rxMode && nibCount >= 1 && nibCount <= 6;
      sreq = act && (!trigMode || trigger || mPend);
      if (!act) begin
        mBusy = 0; mPend = 0; mDone = 0; q.delete();
      end else if (!mBusy) begin
        mDone = 0;
        if (sreq) begin buildFrame(); mBusy = 1; mPend = 0; end
      end else begin
        void'(q.pop_front());
        if (q.size() == 0) begin
          mDone = 1;
          if (sreq) begin buildFrame(); mPend = 0; end
          else mBusy = 0;
        end else begin
          mDone = 0;
          if (trigMode && trigger) mPend = 1;
        end
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      bit expOut;
      expOut = mBusy ? (q[0] ^ mPol) : !invPol;
      chk(txOut == expOut, curReq, int'(txOut), int'(expOut));
      chk(busy == mBusy, "R12", int'(busy), int'(mBusy));
      chk(frameDone == mDone, "R8", int'(frameDone), int'(mDone));
      if (frameDone) doneCnt++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finishRun();
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulseTrig();
    trigger = 1; step(1); trigger = 0;
  endtask

  task automatic idleGap();
    enable = 0; step(4);
  endtask

  initial begin
    step(3);
    chk(txOut == 1'b1, "R2", int'(txOut), 1);
    chk(busy == 1'b0, "R12", int'(busy), 0);
    rstN = 1;
    step(2);

    // R1: inhibited configurations
    curReq = "R1";
    enable = 1; rxMode = 1; step(60);
    chk(busy == 0, "R1", int'(busy), 0);
    rxMode = 0; nibCount = 3'd0; step(60);
    chk(busy == 0, "R1", int'(busy), 0);
    nibCount = 3'd7; step(60);
    chk(busy == 0, "R1", int'(busy), 0);
    chk(doneCnt == 0, "R1", doneCnt, 0);
    idleGap();

    // R3, R4, R8: free-running, six nibbles, CRC on
    curReq = "R4";
    nibCount = 3'd6; statusNib = 4'hC; dataNibs = 24'h9A3F07; crcOn = 1;
    doneCnt = 0; enable = 1; step(700);
    chk(doneCnt >= 2, "R8", doneCnt, 2);
    idleGap();

    // R5: CRC variants
    curReq = "R5";
    nibCount = 3'd1; dataNibs = 24'h000003; enable = 1; step(300);
    idleGap();
    nibCount = 3'd4; dataNibs = 24'h00F1E5; step(1); enable = 1; step(400);
    idleGap();
    nibCount = 3'd3; crcOn = 0; dataNibs = 24'h000ABC; enable = 1; step(300);
    idleGap();

    // R6: pause limiting
    curReq = "R6";
    crcOn = 1; pauseOn = 1; nibCount = 3'd2;
    pauseLen = 10'd5; enable = 1; step(400); idleGap();
    pauseLen = 10'd1000; enable = 1; step(1800); idleGap();
    pauseLen = 10'd100; enable = 1; step(700); idleGap();
    pauseOn = 0;

    // R7: prescaled ticks
    curReq = "R7";
    slowTick = 1; enable = 1; step(1500); idleGap();
    slowTick = 0;

    // R2: inverted polarity
    curReq = "R2";
    invPol = 1; enable = 1; step(600);
    enable = 0; step(2);
    chk(txOut == 1'b0, "R2", int'(txOut), 0);
    invPol = 0; step(2);

    // R9: one frame per trigger
    curReq = "R9";
    trigMode = 1; enable = 1; step(20);
    chk(busy == 0, "R9", int'(busy), 0);
    doneCnt = 0;
    pulseTrig();
    chk(busy == 1, "R9", int'(busy), 1);
    chk(txOut == 1'b0, "R9", int'(txOut), 0);
    step(600);
    chk(doneCnt == 1, "R9", doneCnt, 1);
    chk(busy == 0, "R9", int'(busy), 0);

    // R10: pending trigger, coalesced
    curReq = "R10";
    doneCnt = 0;
    pulseTrig(); step(30); pulseTrig(); step(5); pulseTrig();
    step(800);
    chk(doneCnt == 2, "R10", doneCnt, 2);
    idleGap();
    trigMode = 0;

    // R10: trigger ignored in free-running mode
    enable = 1; step(50); pulseTrig(); step(400);
    idleGap();

    // R11: changes mid-frame do not alter the frame
    curReq = "R11";
    nibCount = 3'd4; dataNibs = 24'h001234; statusNib = 4'h5; enable = 1;
    step(30);
    dataNibs = 24'hFFFFFF; statusNib = 4'hF; invPol = 1; nibCount = 3'd2;
    crcOn = 0; slowTick = 1;
    step(900);
    idleGap();
    invPol = 0; slowTick = 0; crcOn = 1;

    // R1: abort mid-frame
    curReq = "R1";
    doneCnt = 0; enable = 1; step(40);
    chk(busy == 1, "R1", int'(busy), 1);
    rxMode = 1; step(1);
    chk(busy == 0, "R1", int'(busy), 0);
    chk(txOut == 1'b1, "R1", int'(txOut), 1);
    step(5);
    chk(doneCnt == 0, "R1", doneCnt, 0);

    finishRun();
  end
endmodule